// File: doc/BRIEF.md
# Thread-Partitioned Reorder Buffer Allocator

This block hands out entry slots of one ordered structure, such as a reorder buffer or a load/store queue, that several hardware threads share. The structure is cut into partitions of equal size. A thread only ever writes into partitions that belong to it. Each thread therefore keeps its own program order, and it retires and flushes without touching the others. Each thread asks for at most one entry per cycle. In the same cycle the block answers with a grant and the entry index, computed as partition number times partition depth plus the offset inside that partition. Each thread can also commit its oldest entry, or flush all of its entries, in any cycle.

A parameter picks one of two variants. In the fixed variant each thread owns a contiguous region of one thread-count-th of the structure and uses it as a ring. In the on-demand variant a thread holds no partition until it needs one. It then takes the lowest-numbered free partition whenever its current partition is full, and it chains the partitions it holds in age order. A partition goes back to the pool when the head pointer leaves it, or when the thread's in-flight count drops to zero.

A fetch-priority output names the thread with the fewest in-flight entries, so that the front end can favour threads that are not clogging the structure. Ties are resolved in rotating order.

Top module: `rob_part_alloc`

## Requirements
- R1: Fixed variant: thread t owns the entries t*R to t*R+R-1, with R = NPART*PDEPTH/NTHR. Successive grants for thread t take ascending indices in that range and wrap from the last entry back to t*R.
- R2: Fixed variant: `full[t]` is 1 exactly when thread t holds R in-flight entries. While it is 1, an allocate request gets no grant and leaves the in-flight count unchanged.
- R3: On-demand variant: when a thread allocates and holds no partition, or its newest partition has all PDEPTH slots used, it takes the lowest-numbered free partition. Otherwise the grant goes to the next offset of its newest partition. The index is partition*PDEPTH+offset, and the grant and index are valid in the same cycle as the request.
- R4: On-demand variant: `full[t]` is 1 exactly when thread t needs a new partition for its next entry and no partition is free. An allocate request then gets no grant.
- R5: On-demand variant: a partition goes back to the free pool when the commit of its last slot moves the head out of it, or when a commit brings the thread's in-flight count to zero. From the next cycle on it can be granted again.
- R6: A flush of thread t brings its in-flight count to zero in the next cycle and releases only thread t's partitions. Other threads keep their counts and entries. In the fixed variant the next grant of thread t is index t*R.
- R7: A commit to a thread with no in-flight entries is ignored. An allocate and a commit to the same thread in the same cycle both take effect, and the count is unchanged.
- R8: On-demand variant: when several threads need a new partition in the same cycle, the free partitions go to the requesters in ascending thread order. A thread left without one gets no grant.
- R9: `fetch_tid` names a thread whose in-flight count is the lowest of all threads.
- R10: On a tie in in-flight count, `fetch_tid` takes the first tied thread, searching upward from the thread after the previous cycle's choice. After reset the search starts at thread 0.
- R11: `inflight` slice t equals the granted allocations of thread t minus its accepted commits since reset or since its last flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | NTHR | Per-thread request for one new entry |
| commit_req | input | NTHR | Per-thread retire of the oldest entry |
| flush_req | input | NTHR | Per-thread discard of all entries |
| alloc_ok | output | NTHR | Per-thread grant for this cycle's request |
| alloc_idx | output | NTHR*IW | Per-thread granted entry index, thread t in bits t*IW +: IW |
| full | output | NTHR | Per-thread no-room indication |
| inflight | output | NTHR*CW | Per-thread in-flight count, thread t in bits t*CW +: CW |
| fetch_tid | output | TW | Thread preferred for fetch |

## Verification
The bench sweeps every thread's region in the fixed variant through fill, overflow, wrap and flush. A design that got the ring arithmetic wrong would hand out an index outside the region or repeat one. On the on-demand variant it drives the pool until it is empty. It then checks that the lowest thread wins the last partition, that a released partition is handed out again as the lowest free one, and that a commit that empties a thread gives its partition back at once. A design that kept a drained partition would give out index 4 instead of 0 at that point. Ties in the fetch choice must alternate between threads. Unequal counts must pick the lighter thread.

// File: rtl/rpa_pkg.sv
package rpa_pkg;
   typedef enum logic {PART_STATIC = 1'b0, PART_DYNAMIC = 1'b1} part_mode_e;
endpackage

// File: rtl/rpa_thread_ctx.sv
module rpa_thread_ctx import rpa_pkg::*; #(
   parameter part_mode_e  MODE   = PART_DYNAMIC,
   parameter int unsigned NPART  = 8,
   parameter int unsigned PDEPTH = 4,
   parameter int unsigned NTHR   = 4,
   parameter int unsigned TID    = 0,
   localparam int PW  = (NPART > 1) ? $clog2(NPART) : 1,
   localparam int OW  = $clog2(PDEPTH + 1),
   localparam int IW  = $clog2(NPART * PDEPTH),
   localparam int RP  = NPART / NTHR,
   localparam int CAP = (MODE == PART_DYNAMIC) ? NPART * PDEPTH : RP * PDEPTH,
   localparam int CW  = $clog2(CAP + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc_req,
   input  logic          commit_req,
   input  logic          flush_req,
   input  logic          grant,
   input  logic [PW-1:0] grant_part,
   input  logic          any_free,
   input  logic [PW-1:0] hd_next,
   output logic          need,
   output logic          alloc_ok,
   output logic [IW-1:0] alloc_idx,
   output logic          full,
   output logic [CW-1:0] cnt,
   output logic          rel_vld,
   output logic [PW-1:0] rel_part,
   output logic [PW-1:0] hd_part,
   output logic          lnk_we,
   output logic [PW-1:0] lnk_idx,
   output logic [PW-1:0] lnk_val
);
   localparam bit             IS_DYN   = (MODE == PART_DYNAMIC);
   localparam logic [OW-1:0]  OFF_END  = OW'(PDEPTH);
   localparam logic [OW-1:0]  RST_TOFF = IS_DYN ? OFF_END : '0;
   localparam logic [PW-1:0]  BASE     = PW'(TID * RP);

   logic [PW-1:0] hpart_q, tpart_q, np, hsucc, sel_part;
   logic [OW-1:0] hoff_q, toff_q, sel_off;
   logic [CW-1:0] cnt_q, cnt_mid, cnt_n;
   logic          c_ok, tail_done;

   assign tail_done = (toff_q == OFF_END);
   assign c_ok      = commit_req && !flush_req && (cnt_q != '0);
   assign cnt_mid   = cnt_q - CW'(c_ok);
   assign cnt_n     = cnt_mid + CW'(alloc_ok);

   generate
      if (MODE == PART_STATIC) begin : g_fixed
         localparam logic [PW-1:0] LAST = PW'(TID * RP + RP - 1);
         logic unused_fixed;
         assign unused_fixed = ^{grant, grant_part, any_free, hd_next};
         assign np       = (tpart_q == LAST) ? BASE : tpart_q + 1'b1;
         assign hsucc    = (hpart_q == LAST) ? BASE : hpart_q + 1'b1;
         assign full     = (cnt_q == CW'(CAP));
         assign alloc_ok = alloc_req && !flush_req && !full;
         assign need     = 1'b0;
         assign rel_vld  = 1'b0;
         assign lnk_we   = 1'b0;
      end else begin : g_pool
         assign np       = grant_part;
         assign hsucc    = hd_next;
         assign need     = alloc_req && !flush_req && tail_done;
         assign full     = tail_done && !any_free;
         assign alloc_ok = alloc_req && !flush_req && (!tail_done || grant);
         assign rel_vld  = c_ok && ((hoff_q == OFF_END - 1'b1) || (cnt_n == '0));
         assign lnk_we   = alloc_ok && tail_done && (cnt_mid != '0);
      end
   endgenerate

   assign sel_part  = tail_done ? np : tpart_q;
   assign sel_off   = tail_done ? '0 : toff_q;
   assign alloc_idx = IW'(sel_part) * IW'(PDEPTH) + IW'(sel_off);
   assign rel_part  = hpart_q;
   assign hd_part   = hpart_q;
   assign lnk_idx   = tpart_q;
   assign lnk_val   = grant_part;
   assign cnt       = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || flush_req) begin
         cnt_q   <= '0;
         hpart_q <= BASE;
         tpart_q <= BASE;
         hoff_q  <= '0;
         toff_q  <= RST_TOFF;
      end else begin
         cnt_q <= cnt_n;
         if (c_ok) begin
            if (hoff_q == OFF_END - 1'b1) begin
               hoff_q  <= '0;
               hpart_q <= hsucc;
            end else begin
               hoff_q <= hoff_q + 1'b1;
            end
            if (IS_DYN && cnt_n == '0) begin
               hoff_q <= '0;
               toff_q <= OFF_END;
            end
         end
         if (alloc_ok) begin
            if (tail_done) begin
               tpart_q <= np;
               toff_q  <= OW'(1);
               if (IS_DYN && cnt_mid == '0) begin
                  hpart_q <= np;
                  hoff_q  <= '0;
               end
            end else begin
               toff_q <= toff_q + 1'b1;
            end
         end
      end
   end

   // R2 R11
   cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(CAP));
   // R6
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |=> cnt_q == '0);
   // R7
   empty_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_req && cnt_q == '0 && !alloc_req && !flush_req) |=> cnt_q == '0);
   // R4
   grant_vs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_ok |-> !full);
endmodule

// File: rtl/rpa_free_pool.sv
module rpa_free_pool #(
   parameter int unsigned NPART = 8,
   parameter int unsigned NTHR  = 4,
   localparam int PW = (NPART > 1) ? $clog2(NPART) : 1,
   localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NTHR-1:0] need,
   input  logic [NTHR-1:0] flush,
   input  logic [NTHR-1:0] rel_vld,
   input  logic [PW-1:0]   rel_part   [NTHR],
   input  logic [PW-1:0]   hd_part    [NTHR],
   input  logic [NTHR-1:0] lnk_we,
   input  logic [PW-1:0]   lnk_idx    [NTHR],
   input  logic [PW-1:0]   lnk_val    [NTHR],
   output logic [NTHR-1:0] grant,
   output logic [PW-1:0]   grant_part [NTHR],
   output logic            any_free,
   output logic [PW-1:0]   hd_next    [NTHR]
);
   logic [NPART-1:0] free_q, avail, free_d;
   logic [TW-1:0]    owner_q [NPART];
   logic [PW-1:0]    nxt_q   [NPART];

   function automatic logic [PW-1:0] lowest(input logic [NPART-1:0] m);
      logic [PW-1:0] r;
      r = '0;
      for (int p = NPART - 1; p >= 0; p--) begin
         if (m[p]) r = PW'(p);
      end
      return r;
   endfunction

   always_comb begin
      avail = free_q;
      for (int t = 0; t < NTHR; t++) begin
         grant[t]      = 1'b0;
         grant_part[t] = '0;
         if (need[t] && (avail != '0)) begin
            grant[t]             = 1'b1;
            grant_part[t]        = lowest(avail);
            avail[grant_part[t]] = 1'b0;
         end
      end
      free_d = avail;
      for (int t = 0; t < NTHR; t++) begin
         if (rel_vld[t]) free_d[rel_part[t]] = 1'b1;
      end
      for (int p = 0; p < NPART; p++) begin
         if (!free_q[p] && flush[owner_q[p]]) free_d[p] = 1'b1;
      end
   end

   assign any_free = (free_q != '0);

   always_comb begin
      for (int t = 0; t < NTHR; t++) hd_next[t] = nxt_q[hd_part[t]];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_q <= '1;
         for (int p = 0; p < NPART; p++) begin
            owner_q[p] <= '0;
            nxt_q[p]   <= '0;
         end
      end else begin
         free_q <= free_d;
         for (int t = 0; t < NTHR; t++) begin
            if (grant[t])  owner_q[grant_part[t]] <= TW'(t);
            if (lnk_we[t]) nxt_q[lnk_idx[t]]      <= lnk_val[t];
         end
      end
   end

   generate
      for (genvar a = 0; a < NTHR; a++) begin : g_rel
         // R5
         rel_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rel_vld[a] |-> !free_q[rel_part[a]]);
         for (genvar b = a + 1; b < NTHR; b++) begin : g_pair
            // R8
            uniq_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (grant[a] && grant[b]) |-> grant_part[a] != grant_part[b]);
         end
      end
   endgenerate
endmodule

// File: rtl/rpa_fetch_pick.sv
module rpa_fetch_pick #(
   parameter int unsigned NTHR = 4,
   parameter int unsigned CW   = 4,
   localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cnt [NTHR],
   output logic [TW-1:0] tid
);
   logic [TW-1:0] rr_q;
   logic [CW-1:0] best_cnt;

   always_comb begin
      int idx;
      tid      = rr_q;
      best_cnt = cnt[rr_q];
      for (int k = 1; k < NTHR; k++) begin
         idx = (int'(rr_q) + k) % int'(NTHR);
         if (cnt[idx] < best_cnt) begin
            tid      = TW'(idx);
            best_cnt = cnt[idx];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                   rr_q <= '0;
      else if (tid == TW'(NTHR - 1)) rr_q <= '0;
      else                          rr_q <= tid + 1'b1;
   end

   generate
      for (genvar t = 0; t < NTHR; t++) begin : g_min
         // R9
         min_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[tid] <= cnt[t]);
      end
   endgenerate
endmodule

// File: rtl/rob_part_alloc.sv
module rob_part_alloc import rpa_pkg::*; #(
   parameter part_mode_e  MODE   = PART_DYNAMIC,
   parameter int unsigned NTHR   = 4,
   parameter int unsigned NPART  = 8,
   parameter int unsigned PDEPTH = 4,
   localparam int PW  = (NPART > 1) ? $clog2(NPART) : 1,
   localparam int TW  = (NTHR > 1) ? $clog2(NTHR) : 1,
   localparam int IW  = $clog2(NPART * PDEPTH),
   localparam int CAP = (MODE == PART_DYNAMIC) ? NPART * PDEPTH
                                               : (NPART / NTHR) * PDEPTH,
   localparam int CW  = $clog2(CAP + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NTHR-1:0]    alloc_req,
   input  logic [NTHR-1:0]    commit_req,
   input  logic [NTHR-1:0]    flush_req,
   output logic [NTHR-1:0]    alloc_ok,
   output logic [NTHR*IW-1:0] alloc_idx,
   output logic [NTHR-1:0]    full,
   output logic [NTHR*CW-1:0] inflight,
   output logic [TW-1:0]      fetch_tid
);
   generate
      if (NTHR < 2) begin : g_bad_thr
         $error("rob_part_alloc: NTHR must be at least 2");
      end
      if (PDEPTH < 2) begin : g_bad_depth
         $error("rob_part_alloc: PDEPTH must be at least 2");
      end
      if (MODE == PART_STATIC && (NPART % NTHR) != 0) begin : g_bad_div
         $error("rob_part_alloc: NPART must divide evenly among threads");
      end
      if (MODE == PART_DYNAMIC && NPART <= NTHR) begin : g_bad_pool
         $error("rob_part_alloc: NPART must exceed NTHR in on-demand mode");
      end
   endgenerate

   logic [NTHR-1:0] need, grant, rel_vld, lnk_we;
   logic            any_free;
   logic [PW-1:0]   grant_part [NTHR];
   logic [PW-1:0]   hd_next    [NTHR];
   logic [PW-1:0]   rel_part   [NTHR];
   logic [PW-1:0]   hd_part    [NTHR];
   logic [PW-1:0]   lnk_idx    [NTHR];
   logic [PW-1:0]   lnk_val    [NTHR];
   logic [CW-1:0]   cnt        [NTHR];

   generate
      for (genvar t = 0; t < NTHR; t++) begin : g_thr
         rpa_thread_ctx #(
            .MODE(MODE), .NPART(NPART), .PDEPTH(PDEPTH), .NTHR(NTHR), .TID(t)
         ) u_ctx (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_req  (alloc_req[t]),
            .commit_req (commit_req[t]),
            .flush_req  (flush_req[t]),
            .grant      (grant[t]),
            .grant_part (grant_part[t]),
            .any_free   (any_free),
            .hd_next    (hd_next[t]),
            .need       (need[t]),
            .alloc_ok   (alloc_ok[t]),
            .alloc_idx  (alloc_idx[t*IW +: IW]),
            .full       (full[t]),
            .cnt        (cnt[t]),
            .rel_vld    (rel_vld[t]),
            .rel_part   (rel_part[t]),
            .hd_part    (hd_part[t]),
            .lnk_we     (lnk_we[t]),
            .lnk_idx    (lnk_idx[t]),
            .lnk_val    (lnk_val[t])
         );
         assign inflight[t*CW +: CW] = cnt[t];
      end

      if (MODE == PART_DYNAMIC) begin : g_dyn
         rpa_free_pool #(.NPART(NPART), .NTHR(NTHR)) u_pool (
            .clk        (clk),
            .rst_n      (rst_n),
            .need       (need),
            .flush      (flush_req),
            .rel_vld    (rel_vld),
            .rel_part   (rel_part),
            .hd_part    (hd_part),
            .lnk_we     (lnk_we),
            .lnk_idx    (lnk_idx),
            .lnk_val    (lnk_val),
            .grant      (grant),
            .grant_part (grant_part),
            .any_free   (any_free),
            .hd_next    (hd_next)
         );
      end else begin : g_fix
         logic [NTHR-1:0] unused_fix;
         assign grant    = '0;
         assign any_free = 1'b0;
         for (genvar t = 0; t < NTHR; t++) begin : g_tie
            assign grant_part[t] = '0;
            assign hd_next[t]    = '0;
            assign unused_fix[t] = ^{need[t], rel_vld[t], rel_part[t], hd_part[t],
                                     lnk_we[t], lnk_idx[t], lnk_val[t]};
         end
      end
   endgenerate

   rpa_fetch_pick #(.NTHR(NTHR), .CW(CW)) u_fetch (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   (cnt),
      .tid   (fetch_tid)
   );
endmodule

// File: tb/rob_part_alloc_tb.sv
`timescale 1ns/1ps
module rob_part_alloc_tb;
   import rpa_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [1:0] d_alloc = '0, d_commit = '0, d_flush = '0;
   logic [1:0] d_ok, d_full;
   logic [5:0] d_idx;
   logic [7:0] d_inf;
   logic [0:0] d_tid;

   logic [1:0] s_alloc = '0, s_commit = '0, s_flush = '0;
   logic [1:0] s_ok, s_full;
   logic [5:0] s_idx;
   logic [5:0] s_inf;
   logic [0:0] s_tid;

   rob_part_alloc #(.MODE(PART_DYNAMIC), .NTHR(2), .NPART(4), .PDEPTH(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .alloc_req(d_alloc), .commit_req(d_commit),
      .flush_req(d_flush), .alloc_ok(d_ok), .alloc_idx(d_idx), .full(d_full),
      .inflight(d_inf), .fetch_tid(d_tid));

   rob_part_alloc #(.MODE(PART_STATIC), .NTHR(2), .NPART(4), .PDEPTH(2)) u_dut_s (
      .clk(clk), .rst_n(rst_n), .alloc_req(s_alloc), .commit_req(s_commit),
      .flush_req(s_flush), .alloc_ok(s_ok), .alloc_idx(s_idx), .full(s_full),
      .inflight(s_inf), .fetch_tid(s_tid));

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;
   logic [1:0] c_ok;
   int c_idx0, c_idx1, c_tid;

   task automatic chk_eq(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step_d(input logic [1:0] a, input logic [1:0] c, input logic [1:0] f);
      @(negedge clk);
      d_alloc = a; d_commit = c; d_flush = f;
      #1;
      c_ok = d_ok; c_idx0 = int'(d_idx[2:0]); c_idx1 = int'(d_idx[5:3]); c_tid = int'(d_tid);
      @(posedge clk);
      #1;
      d_alloc = '0; d_commit = '0; d_flush = '0;
   endtask

   task automatic step_s(input logic [1:0] a, input logic [1:0] c, input logic [1:0] f);
      @(negedge clk);
      s_alloc = a; s_commit = c; s_flush = f;
      #1;
      c_ok = s_ok; c_idx0 = int'(s_idx[2:0]); c_idx1 = int'(s_idx[5:3]);
      @(posedge clk);
      #1;
      s_alloc = '0; s_commit = '0; s_flush = '0;
   endtask

   function automatic int s_cnt(input int t);
      return (t == 0) ? int'(s_inf[2:0]) : int'(s_inf[5:3]);
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk_eq("R11 reset inflight dyn", int'(d_inf), 0);
      chk_eq("R11 reset inflight fixed", int'(s_inf), 0);
      chk_eq("R4 reset full dyn", int'(d_full), 0);
      chk_eq("R2 reset full fixed", int'(s_full), 0);
      chk_eq("R10 reset fetch start", int'(d_tid), 0);
      step_d(2'b00, 2'b00, 2'b00);
      chk_eq("R10 tie rotates", c_tid, 1);
      step_d(2'b00, 2'b00, 2'b00);
      chk_eq("R10 tie rotates back", c_tid, 0);

      // ---------------- fixed variant sweep (R1 R2 R6)
      for (int t = 0; t < 2; t++) begin
         logic [1:0] m;
         m = 2'(1 << t);
         for (int k = 0; k < 5; k++) begin
            step_s(m, 2'b00, 2'b00);
            chk_eq("R2 grant while room", int'(c_ok[t]), (k < 4) ? 1 : 0);
            if (k < 4) chk_eq("R1 region index", (t == 0) ? c_idx0 : c_idx1, t * 4 + k);
         end
         chk_eq("R2 full at region size", int'(s_full[t]), 1);
         chk_eq("R2 count unchanged by refused alloc", s_cnt(t), 4);
         if (t == 1) chk_eq("R6 other thread untouched", s_cnt(0), 1);
         step_s(2'b00, m, 2'b00);
         step_s(2'b00, m, 2'b00);
         chk_eq("R11 count after commits", s_cnt(t), 2);
         chk_eq("R2 full drops", int'(s_full[t]), 0);
         for (int k = 0; k < 2; k++) begin
            step_s(m, 2'b00, 2'b00);
            chk_eq("R1 wrap index", (t == 0) ? c_idx0 : c_idx1, t * 4 + k);
         end
         step_s(2'b00, 2'b00, m);
         chk_eq("R6 flush clears count", s_cnt(t), 0);
         step_s(m, 2'b00, 2'b00);
         chk_eq("R6 flush restarts region", (t == 0) ? c_idx0 : c_idx1, t * 4);
      end
      step_s(2'b11, 2'b00, 2'b00);
      chk_eq("R1 parallel grant t0", c_idx0, 1);
      chk_eq("R1 parallel grant t1", c_idx1, 5);
      step_s(2'b01, 2'b01, 2'b00);
      chk_eq("R7 alloc+commit index", c_idx0, 2);
      chk_eq("R7 alloc+commit count", s_cnt(0), 2);

      // ---------------- on-demand variant (R3 R4 R5 R6 R7 R8 R9)
      step_d(2'b01, 2'b00, 2'b00); chk_eq("R3 first partition", c_idx0, 0);
      step_d(2'b01, 2'b00, 2'b00); chk_eq("R3 next offset", c_idx0, 1);
      step_d(2'b01, 2'b00, 2'b00); chk_eq("R3 new partition lowest free", c_idx0, 2);
      chk_eq("R11 count t0", int'(d_inf[3:0]), 3);
      #1 chk_eq("R9 lighter thread preferred", int'(d_tid), 1);
      step_d(2'b10, 2'b00, 2'b00); chk_eq("R3 t1 first partition", c_idx1, 4);
      step_d(2'b01, 2'b00, 2'b00); chk_eq("R3 fill partition", c_idx0, 3);
      step_d(2'b01, 2'b00, 2'b00); chk_eq("R3 last free partition", c_idx0, 6);
      step_d(2'b01, 2'b00, 2'b00); chk_eq("R3 offset in last", c_idx0, 7);
      step_d(2'b10, 2'b00, 2'b00); chk_eq("R3 t1 second slot", c_idx1, 5);
      chk_eq("R4 both full", int'(d_full), 3);
      step_d(2'b11, 2'b00, 2'b00);
      chk_eq("R4 no grant when full", int'(c_ok), 0);
      chk_eq("R4 counts unchanged", int'(d_inf), 8'h26);
      step_d(2'b00, 2'b01, 2'b00);
      step_d(2'b00, 2'b01, 2'b00);
      chk_eq("R5 released partition clears full", int'(d_full), 0);
      step_d(2'b10, 2'b00, 2'b00);
      chk_eq("R5 reuse released partition", c_idx1, 0);
      step_d(2'b00, 2'b00, 2'b01);
      chk_eq("R6 flush count t0", int'(d_inf[3:0]), 0);
      chk_eq("R6 flush leaves t1", int'(d_inf[7:4]), 3);
      #1 chk_eq("R9 empty thread preferred", int'(d_tid), 0);
      step_d(2'b01, 2'b00, 2'b00); chk_eq("R6 flushed partition back", c_idx0, 2);
      step_d(2'b01, 2'b00, 2'b00); chk_eq("R3 fill after flush", c_idx0, 3);
      step_d(2'b10, 2'b00, 2'b00); chk_eq("R3 t1 fill", c_idx1, 1);
      step_d(2'b11, 2'b00, 2'b00);
      chk_eq("R8 lower thread wins", int'(c_ok), 1);
      chk_eq("R8 winner index", c_idx0, 6);
      for (int k = 0; k < 4; k++) step_d(2'b00, 2'b10, 2'b00);
      chk_eq("R11 t1 drained", int'(d_inf[7:4]), 0);
      step_d(2'b00, 2'b10, 2'b00);
      chk_eq("R7 empty commit ignored", int'(d_inf[7:4]), 0);
      step_d(2'b10, 2'b00, 2'b00);
      chk_eq("R5 lowest free after drain", c_idx1, 0);
      step_d(2'b01, 2'b01, 2'b00);
      chk_eq("R7 alloc+commit index dyn", c_idx0, 7);
      chk_eq("R7 alloc+commit count dyn", int'(d_inf[3:0]), 3);
      step_d(2'b00, 2'b10, 2'b00);
      step_d(2'b01, 2'b00, 2'b00);
      chk_eq("R5 zero count releases partition", c_idx0, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule